// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block lets a host reach packet memory one byte at a time. The host first loads a 16-bit pointer, one byte at a time. It then reads or writes through a four-byte data window. The top two pointer bits are control flags. One flag picks the page: either the page at the head of the receive queue or the page named by the packet-number register. Both page numbers arrive as inputs. The other flag turns on auto-increment. The low eleven bits give the byte offset inside the 2048-byte page.

With auto-increment on, every byte access through the window steps the offset by one, and the step wraps inside the page. With auto-increment off, the pointer stays put and the low two bits of the window address are added to the offset. This lets the host reach four neighbouring bytes without reloading the pointer. The four pages of memory sit inside the block. The memory is synchronous, and its one cycle of read latency is hidden behind a request/acknowledge strobe.

Top module: `pdp_data_port`

## Requirements
- R1: After reset the pointer is zero, so reads of offsets 6 and 7 return 0x00, and the acknowledge output is low.
- R2: A write to offset 6 loads pointer bits 7:0 and a write to offset 7 loads pointer bits 15:8; a read of offset 6 returns pointer bits 7:0.
- R3: A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7, so bit 3 of the returned byte is always 0.
- R4: With pointer bit 15 set, window accesses go to the page on `rxq_head_pg`; with it clear, they go to the page on `pkt_num_pg`.
- R5: Pointer bits 10:0 give the byte offset within the selected page.
- R6: With pointer bit 14 set, each window byte access uses offset bits 10:0 unchanged, then increments bits 10:0 modulo 2048 while bits 15:11 stay as they were. A 16-bit transfer made of two byte accesses therefore advances the pointer by 2.
- R7: With pointer bit 14 clear, a window access at offset 8+k (k = 0..3) uses byte offset (bits 10:0 + k) modulo 2048 within the same page, and the pointer is not changed.
- R8: Each request cycle is answered by the acknowledge output exactly one cycle later, and read data is valid in that same cycle. Requests may come on consecutive cycles; a cycle without a request gives no acknowledge.
- R9: Writes to offsets outside 6 to 11 change neither the pointer nor the memory, and reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxq_head_pg | input | PG_W | Page number at the head of the receive queue |
| pkt_num_pg | input | PG_W | Page number held by the packet-number register |
| hst_req | input | 1 | Host access strobe, one cycle per byte access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 4 | Byte offset in the register space (6, 7 = pointer; 8 to 11 = data window) |
| hst_wdata | input | 8 | Write data |
| hst_ack | output | 1 | Acknowledge, one cycle after the request |
| hst_rdata | output | 8 | Read data, valid while `hst_ack` is high |

## Verification
The window is exercised in three pointer modes: auto-increment on the packet-number page, fixed pointer with window address offsets, and the receive-head page selected by bit 15. The same data is read back in the other modes, which shows whether the increment and the address-offset rule are applied at the right times and never together. Reads of one offset under the two page selections, holding different data, show whether the page multiplexer follows bit 15. Loading offset 0x7FF in both modes shows that wrapping stays inside the page and leaves bits 15:11 intact. Back-to-back reads and writes to unmapped offsets show that the pointer and the return path do not leak state between accesses.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
    localparam int PTR_W      = 16;
    localparam int PTR_RX_BIT = 15;
    localparam int PTR_AI_BIT = 14;

    localparam logic [3:0] OFS_PTR_LO = 4'd6;
    localparam logic [3:0] OFS_PTR_HI = 4'd7;
    localparam logic [1:0] WIN_TAG    = 2'b10;   // addr[3:2] of offsets 8..11
    localparam logic [7:0] HI_RD_MASK = 8'hF7;

    typedef enum logic [1:0] {
        RSRC_NONE = 2'd0,
        RSRC_REG  = 2'd1,
        RSRC_RAM  = 2'd2
    } rsrc_e;

    typedef struct packed {
        logic       ack;
        rsrc_e      src;
        logic [7:0] reg_byte;
    } rsp_t;
endpackage

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
    import pdp_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       ld_byte,
    input  logic             win_acc,
    output logic [PTR_W-1:0] ptr_q
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_lo) begin
            st_d.ptr[7:0] = ld_byte;
        end else if (ld_hi) begin
            st_d.ptr[15:8] = ld_byte;
        end else if (win_acc && st_q.ptr[PTR_AI_BIT]) begin
            st_d.ptr[OFS_W-1:0] = st_q.ptr[OFS_W-1:0] + OFS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q = st_q.ptr;

    // R6: auto-increment steps the offset field and keeps the upper bits
    p_auto_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !ld_lo && !ld_hi && ptr_q[PTR_AI_BIT]) |=>
            (ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W])) &&
            (ptr_q[OFS_W-1:0] == OFS_W'($past(ptr_q[OFS_W-1:0]) + OFS_W'(1))));

    // R7: without auto-increment a window access leaves the pointer alone
    p_hold_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !ld_lo && !ld_hi && !ptr_q[PTR_AI_BIT]) |=> $stable(ptr_q));

    // R2: a low-byte load leaves the high byte untouched
    p_lo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (ptr_q[15:8] == $past(ptr_q[15:8])) && (ptr_q[7:0] == $past(ld_byte)));
endmodule

// File: rtl/pdp_addr_gen.sv
module pdp_addr_gen #(
    parameter int PG_W  = 2,
    parameter int OFS_W = 11
) (
    input  logic             sel_rx,
    input  logic             auto_inc,
    input  logic [OFS_W-1:0] ptr_ofs,
    input  logic [1:0]       win_lane,
    input  logic [PG_W-1:0]  rxq_head_pg,
    input  logic [PG_W-1:0]  pkt_num_pg,
    output logic [PG_W-1:0]  acc_pg,
    output logic [OFS_W-1:0] acc_ofs
);
    localparam int PAD_W = OFS_W - 2;

    logic [OFS_W-1:0] lane_ext;

    always_comb begin
        lane_ext = {{PAD_W{1'b0}}, win_lane};
        acc_pg   = sel_rx ? rxq_head_pg : pkt_num_pg;
        acc_ofs  = auto_inc ? ptr_ofs : ptr_ofs + lane_ext;
    end
endmodule

// File: rtl/pdp_byte_ram.sv
module pdp_byte_ram #(
    parameter int PG_W  = 2,
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [PG_W-1:0]  pg,
    input  logic [OFS_W-1:0] ofs,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    localparam int LANES  = 4;
    localparam int WIDX_W = PG_W + OFS_W - 2;
    localparam int WORDS  = 1 << WIDX_W;

    logic [LANES*8-1:0] mem [WORDS];
    logic [LANES*8-1:0] rd_word_q;
    logic [1:0]         lane_q;
    logic [WIDX_W-1:0]  widx;
    logic [1:0]         lane;

    assign widx = {pg, ofs[OFS_W-1:2]};
    assign lane = ofs[1:0];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[widx][lane*8 +: 8] <= wdata;
            rd_word_q <= mem[widx];
            lane_q    <= lane;
        end
    end

    assign rdata = rd_word_q[lane_q*8 +: 8];
endmodule

// File: rtl/pdp_data_port.sv
module pdp_data_port
    import pdp_pkg::*;
#(
    parameter int NUM_PG = 4,
    parameter int OFS_W  = 11,
    parameter int PG_W   = $clog2(NUM_PG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PG_W-1:0] rxq_head_pg,
    input  logic [PG_W-1:0] pkt_num_pg,
    input  logic            hst_req,
    input  logic            hst_wr,
    input  logic [3:0]      hst_addr,
    input  logic [7:0]      hst_wdata,
    output logic            hst_ack,
    output logic [7:0]      hst_rdata
);
    logic             is_lo, is_hi, is_win;
    logic             win_acc;
    logic [PTR_W-1:0] ptr_q;
    logic [PG_W-1:0]  acc_pg;
    logic [OFS_W-1:0] acc_ofs;
    logic [7:0]       ram_rd;
    rsp_t             rsp_d, rsp_q;

    assign is_lo   = (hst_addr == OFS_PTR_LO);
    assign is_hi   = (hst_addr == OFS_PTR_HI);
    assign is_win  = (hst_addr[3:2] == WIN_TAG);
    assign win_acc = hst_req && is_win;

    pdp_ptr_reg #(.OFS_W(OFS_W)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (hst_req && hst_wr && is_lo),
        .ld_hi   (hst_req && hst_wr && is_hi),
        .ld_byte (hst_wdata),
        .win_acc (win_acc),
        .ptr_q   (ptr_q)
    );

    pdp_addr_gen #(.PG_W(PG_W), .OFS_W(OFS_W)) agen_i (
        .sel_rx      (ptr_q[PTR_RX_BIT]),
        .auto_inc    (ptr_q[PTR_AI_BIT]),
        .ptr_ofs     (ptr_q[OFS_W-1:0]),
        .win_lane    (hst_addr[1:0]),
        .rxq_head_pg (rxq_head_pg),
        .pkt_num_pg  (pkt_num_pg),
        .acc_pg      (acc_pg),
        .acc_ofs     (acc_ofs)
    );

    pdp_byte_ram #(.PG_W(PG_W), .OFS_W(OFS_W)) ram_i (
        .clk   (clk),
        .en    (win_acc),
        .we    (hst_wr),
        .pg    (acc_pg),
        .ofs   (acc_ofs),
        .wdata (hst_wdata),
        .rdata (ram_rd)
    );

    always_comb begin
        rsp_d          = '0;
        rsp_d.ack      = hst_req;
        rsp_d.src      = RSRC_NONE;
        if (hst_req && !hst_wr) begin
            if (is_lo) begin
                rsp_d.src      = RSRC_REG;
                rsp_d.reg_byte = ptr_q[7:0];
            end else if (is_hi) begin
                rsp_d.src      = RSRC_REG;
                rsp_d.reg_byte = ptr_q[15:8] & HI_RD_MASK;
            end else if (is_win) begin
                rsp_d.src      = RSRC_RAM;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    always_comb begin
        hst_ack = rsp_q.ack;
        unique case (rsp_q.src)
            RSRC_REG: hst_rdata = rsp_q.reg_byte;
            RSRC_RAM: hst_rdata = ram_rd;
            default:  hst_rdata = 8'h00;
        endcase
    end

    // R8: every request is acknowledged in the following cycle
    p_ack_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hst_req |=> hst_ack);

    // R8: no acknowledge without a request
    p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_req |=> !hst_ack);

    // R3: bit 11 of the pointer never reaches the read port
    p_hi_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_wr && is_hi) |=> (hst_rdata[3] == 1'b0));

    // R9: writes outside the pointer and window leave the pointer unchanged
    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && hst_wr && !is_lo && !is_hi && !is_win) |=> $stable(ptr_q));

    // R9: reads outside the pointer and window return zero
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_wr && !is_lo && !is_hi && !is_win) |=> (hst_rdata == 8'h00));
endmodule

// File: tb/pdp_data_port_tb_top.sv
module pdp_data_port_tb_top;
    localparam int NV = 46;

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] wd;
        logic [7:0] exp;
        logic [3:0] rq;
    } vec_t;

    // Page inputs during the table: receive head = 2, packet number = 1.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd6,  8'h10, 8'h00, 4'd2},  // R2 ptr lo
        '{1'b1, 4'd7,  8'h40, 8'h00, 4'd2},  // R2 ptr = 0x4010, auto-inc
        '{1'b1, 4'd8,  8'hA1, 8'h00, 4'd6},  // R6 ofs 0x10
        '{1'b1, 4'd9,  8'hA2, 8'h00, 4'd6},  // R6 ofs 0x11
        '{1'b1, 4'd10, 8'hA3, 8'h00, 4'd6},  // R6 ofs 0x12
        '{1'b0, 4'd6,  8'h00, 8'h13, 4'd6},  // R6 three steps
        '{1'b1, 4'd6,  8'h10, 8'h00, 4'd2},
        '{1'b0, 4'd8,  8'h00, 8'hA1, 4'd5},  // R5
        '{1'b0, 4'd11, 8'h00, 8'hA2, 4'd6},  // R6 lane ignored
        '{1'b0, 4'd8,  8'h00, 8'hA3, 4'd6},
        '{1'b1, 4'd7,  8'h00, 8'h00, 4'd2},  // ptr 0x0013
        '{1'b1, 4'd6,  8'h10, 8'h00, 4'd2},  // ptr 0x0010
        '{1'b0, 4'd8,  8'h00, 8'hA1, 4'd7},  // R7 +0
        '{1'b0, 4'd9,  8'h00, 8'hA2, 4'd7},  // R7 +1
        '{1'b0, 4'd10, 8'h00, 8'hA3, 4'd7},  // R7 +2
        '{1'b0, 4'd6,  8'h00, 8'h10, 4'd7},  // R7 pointer held
        '{1'b1, 4'd11, 8'h5C, 8'h00, 4'd7},  // R7 ofs 0x13
        '{1'b1, 4'd7,  8'h80, 8'h00, 4'd4},  // R4 ptr 0x8010, rx page
        '{1'b1, 4'd9,  8'h77, 8'h00, 4'd4},  // page 2 ofs 0x11
        '{1'b0, 4'd9,  8'h00, 8'h77, 4'd4},
        '{1'b1, 4'd7,  8'h00, 8'h00, 4'd4},  // back to page 1
        '{1'b0, 4'd9,  8'h00, 8'hA2, 4'd4},  // R4 page 1 kept its data
        '{1'b0, 4'd11, 8'h00, 8'h5C, 4'd7},
        '{1'b1, 4'd7,  8'hFF, 8'h00, 4'd3},  // ptr 0xFF10
        '{1'b0, 4'd7,  8'h00, 8'hF7, 4'd3},  // R3 mask
        '{1'b1, 4'd6,  8'hFF, 8'h00, 4'd6},  // ptr 0xFFFF, ofs 0x7FF
        '{1'b1, 4'd8,  8'h3C, 8'h00, 4'd6},  // page 2 ofs 0x7FF, wrap
        '{1'b0, 4'd6,  8'h00, 8'h00, 4'd6},  // R6 wrapped to 0
        '{1'b0, 4'd7,  8'h00, 8'hF0, 4'd6},  // R6 upper bits kept
        '{1'b1, 4'd8,  8'h4D, 8'h00, 4'd6},  // page 2 ofs 0
        '{1'b1, 4'd7,  8'h87, 8'h00, 4'd7},  // ptr 0x8701
        '{1'b1, 4'd6,  8'hFF, 8'h00, 4'd7},  // ptr 0x87FF
        '{1'b0, 4'd8,  8'h00, 8'h3C, 4'd7},  // R7 ofs 0x7FF
        '{1'b0, 4'd9,  8'h00, 8'h4D, 4'd7},  // R7 wraps to ofs 0
        '{1'b0, 4'd7,  8'h00, 8'h87, 4'd3},
        '{1'b1, 4'd0,  8'h55, 8'h00, 4'd9},  // R9 ignored
        '{1'b1, 4'd12, 8'h66, 8'h00, 4'd9},  // R9 ignored
        '{1'b0, 4'd6,  8'h00, 8'hFF, 4'd9},
        '{1'b0, 4'd7,  8'h00, 8'h87, 4'd9},
        '{1'b0, 4'd3,  8'h00, 8'h00, 4'd9},
        '{1'b0, 4'd15, 8'h00, 8'h00, 4'd9},
        '{1'b1, 4'd7,  8'h40, 8'h00, 4'd6},  // ptr 0x40FF
        '{1'b1, 4'd6,  8'h10, 8'h00, 4'd6},  // ptr 0x4010
        '{1'b0, 4'd8,  8'h00, 8'hA1, 4'd6},  // 16-bit: byte 0
        '{1'b0, 4'd9,  8'h00, 8'hA2, 4'd6},  // 16-bit: byte 1
        '{1'b0, 4'd6,  8'h00, 8'h12, 4'd6}   // R6 advanced by 2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rxq_head_pg = 2'd2;
    logic [1:0] pkt_num_pg = 2'd1;
    logic       hst_req = 1'b0;
    logic       hst_wr = 1'b0;
    logic [3:0] hst_addr = 4'd0;
    logic [7:0] hst_wdata = 8'h00;
    logic       hst_ack;
    logic [7:0] hst_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pdp_data_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxq_head_pg (rxq_head_pg),
        .pkt_num_pg  (pkt_num_pg),
        .hst_req     (hst_req),
        .hst_wr      (hst_wr),
        .hst_addr    (hst_addr),
        .hst_wdata   (hst_wdata),
        .hst_ack     (hst_ack),
        .hst_rdata   (hst_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; returns the acknowledged response.
    task automatic access(input logic wr, input logic [3:0] a, input logic [7:0] d,
                          output logic ack, output logic [7:0] rd);
        hst_req   = 1'b1;
        hst_wr    = wr;
        hst_addr  = a;
        hst_wdata = d;
        @(negedge clk);
        hst_req = 1'b0;
        ack = hst_ack;
        rd  = hst_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic       ack;
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ack idle", {7'd0, hst_ack}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 4'd6, 8'h00, ack, rd);
        check("R1 ptr lo", rd, 8'h00);
        access(1'b0, 4'd7, 8'h00, ack, rd);
        check("R1 ptr hi", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wd, ack, rd);
            check($sformatf("R8 ack vec %0d", i), {7'd0, ack}, 8'h01);
            if (!VECS[i].wr)
                check($sformatf("R%0d vec %0d", VECS[i].rq, i), rd, VECS[i].exp);
        end

        // R4: page inputs swapped while pointer selects the packet-number page
        pkt_num_pg = 2'd2;
        access(1'b1, 4'd6, 8'h11, ack, rd);       // ptr 0x4011, auto-inc
        access(1'b0, 4'd8, 8'h00, ack, rd);       // page 2 ofs 0x11
        check("R4 page follows input", rd, 8'h77);
        pkt_num_pg = 2'd1;

        // R8: back-to-back reads
        access(1'b1, 4'd6, 8'h10, ack, rd);       // ptr 0x4010
        hst_req = 1'b1; hst_wr = 1'b0; hst_addr = 4'd8;
        @(negedge clk);
        check("R8 b2b ack0", {7'd0, hst_ack}, 8'h01);
        check("R8 b2b data0", hst_rdata, 8'hA1);
        @(negedge clk);
        hst_req = 1'b0;
        check("R8 b2b ack1", {7'd0, hst_ack}, 8'h01);
        check("R8 b2b data1", hst_rdata, 8'hA2);
        @(negedge clk);
        check("R8 idle no ack", {7'd0, hst_ack}, 8'h00);

        // R9: unmapped write did not touch memory
        access(1'b1, 4'd7, 8'h00, ack, rd);       // ptr 0x0012, page 1
        access(1'b1, 4'd0, 8'hEE, ack, rd);
        access(1'b0, 4'd8, 8'h00, ack, rd);
        check("R9 memory untouched", rd, 8'hA3);

        // R1: reset mid-run clears the pointer
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 ack in reset", {7'd0, hst_ack}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 4'd6, 8'h00, ack, rd);
        check("R1 ptr lo after reset", rd, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule